// File: doc/BRIEF.md
# Dynamic TDMA Inter-Layer Pillar Bus Arbiter

This block arbitrates the single shared vertical bus of one pillar that joins a small stack of device layers. Each layer raises a request line when it holds flits to send, together with the index of the layer it wants to reach and the 128-bit flit itself. The arbiter builds a frame of time slots from the layers that are requesting at a frame boundary. Each requesting layer gets exactly one slot per frame, and the slots run in ascending layer order. In each slot one layer's transmit driver is enabled and the receiver of the layer it addresses is enabled, so a flit crosses from any layer to any other in one hop.

The driver enables come from one small feedback shift register per layer. At every frame boundary the arbiter loads each register with a one-hot pattern that marks the layer's slot. During the frame the register rotates within the frame length. A change in the requester set is picked up only at the next boundary. A layer that withdraws its request in the middle of a frame leaves its slot empty and does not shorten the frame. When no layer requests, the bus sits idle with every driver off.

One instance serves one pillar. The number of layers is a parameter from 2 to 4.

Top module: `dtdma_pillar_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all transmit enables and receive enables are low, `bus_valid_o` is low and `bus_data_o` is zero.
- R2: At most one bit of `tx_en_o` is high in any cycle.
- R3: `tx_en_o[i]` is high only while `req_i[i]` is high.
- R4: At a frame boundary the frame length becomes the number of requesting layers. Each of those layers owns exactly one slot in the frame, so a set of k steady requesters repeats with period k.
- R5: Within a frame the slots go to the latched requesters in ascending layer index, starting with the lowest.
- R6: A layer that starts requesting in the middle of a frame gets no slot until the next frame begins, and the current frame keeps its length.
- R7: While a layer transmits, `rx_en_o` is one-hot at the layer index given by that transmitter's `dst_i` field, which is the binary index of the destination layer. `rx_en_o` is zero when nothing transmits.
- R8: `bus_data_o` equals the transmitting layer's `flit_i` entry and `bus_valid_o` is high. With no transmitter, `bus_data_o` is zero and `bus_valid_o` is low.
- R9: With no layer requesting, the bus stays idle with every transmit enable low.
- R10: A layer that drops its request before its slot leaves that slot empty. The following slots of the same frame are unchanged.
- R11: From an idle bus, a request present at a clock edge gives the lowest requesting layer the bus immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | LAYERS | Per-layer request, high while the layer has flits to send |
| dst_i | input | LAYERS*IDX_W | Per-layer destination layer index (binary) |
| flit_i | input | LAYERS*FLIT_W | Per-layer flit offered to the bus |
| tx_en_o | output | LAYERS | Per-layer transmit driver enable |
| rx_en_o | output | LAYERS | Per-layer receiver enable |
| bus_valid_o | output | 1 | A flit is on the bus this cycle |
| bus_data_o | output | FLIT_W | Resolved bus value (zero when no driver is on) |

## Verification
The frame latch and slot advance happen at a clock edge, and the enables, receive decode and bus value follow combinationally from the registered patterns and the live requests. Every grant is therefore due in the cycle right after the edge that latched or advanced it. The bench drives inputs at the falling edge. A behavioural frame queue advances at the rising edge, and all outputs are compared at the next falling edge, half a period after the grant edge, before any input is changed. A late joiner (R6) is due one full frame after it rises. A dropped slot (R10) is empty in the very cycle its request falls, and the per-cycle transmitter log is checked against these positions.

// File: rtl/dtdma_pkg.sv
package dtdma_pkg;
    localparam int unsigned MIN_LAYERS = 2;
    localparam int unsigned MAX_LAYERS = 4;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_mode_e;
endpackage

// File: rtl/dtdma_slot_seq.sv
// Frame sequencer: latches the requester set at each boundary, counts slots
// and gives every requester its rank inside the frame.
module dtdma_slot_seq
    import dtdma_pkg::*;
#(
    parameter int unsigned LAYERS = 4,
    localparam int unsigned CNT_W = $clog2(LAYERS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LAYERS-1:0]             req,
    output logic                          at_boundary,
    output logic [CNT_W-1:0]              frame_len,
    output logic [CNT_W-1:0]              slot,
    output logic [LAYERS-1:0][CNT_W-1:0]  rank
);
    typedef struct packed {
        seq_mode_e        mode;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] slot;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [CNT_W-1:0] active_cnt;

    always_comb begin
        logic [CNT_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < LAYERS; i++) begin
            rank[i] = acc;
            acc     = acc + CNT_W'(req[i]);
        end
        active_cnt = acc;
    end

    always_comb begin
        at_boundary = (st_q.mode == SEQ_IDLE) ||
                      (st_q.slot == CNT_W'(st_q.len - 1'b1));
        st_d = st_q;
        if (at_boundary) begin
            st_d.len  = active_cnt;
            st_d.slot = '0;
            st_d.mode = (active_cnt != '0) ? SEQ_RUN : SEQ_IDLE;
        end else begin
            st_d.slot = st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: SEQ_IDLE, len: '0, slot: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_len = st_q.len;
    assign slot      = st_q.slot;
endmodule

// File: rtl/dtdma_pattern_sr.sv
// One layer's feedback shift register. Loaded with a one-hot slot marker at
// each boundary, rotated within the frame length in between.
module dtdma_pattern_sr #(
    parameter int unsigned LAYERS = 4,
    localparam int unsigned CNT_W = $clog2(LAYERS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             member,
    input  logic [CNT_W-1:0] rank,
    input  logic [CNT_W-1:0] frame_len,
    output logic             slot_bit
);
    typedef struct packed {
        logic [LAYERS-1:0] pat;
    } sr_state_t;

    sr_state_t sr_d, sr_q;
    logic [LAYERS:0] ext;

    always_comb begin
        ext  = {1'b0, sr_q.pat};
        sr_d = sr_q;
        if (load) begin
            sr_d.pat = member ? (LAYERS'(1) << rank) : '0;
        end else begin
            for (int k = 0; k < LAYERS; k++) begin
                if (k == int'(frame_len) - 1) begin
                    sr_d.pat[k] = sr_q.pat[0];
                end else begin
                    sr_d.pat[k] = ext[k+1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '{pat: '0};
        end else begin
            sr_q <= sr_d;
        end
    end

    assign slot_bit = sr_q.pat[0];
endmodule

// File: rtl/dtdma_bus_mux.sv
// Resolves the shared bus: wired-OR of gated drivers and receiver decode.
module dtdma_bus_mux #(
    parameter int unsigned LAYERS = 4,
    parameter int unsigned FLIT_W = 128,
    localparam int unsigned IDX_W = $clog2(LAYERS)
) (
    input  logic [LAYERS-1:0]             tx_en,
    input  logic [LAYERS-1:0][IDX_W-1:0]  dst,
    input  logic [LAYERS-1:0][FLIT_W-1:0] flit,
    output logic [LAYERS-1:0]             rx_en,
    output logic                          bus_valid,
    output logic [FLIT_W-1:0]             bus_data
);
    always_comb begin
        bus_data  = '0;
        rx_en     = '0;
        bus_valid = 1'b0;
        for (int i = 0; i < LAYERS; i++) begin
            bus_data  = bus_data | (flit[i] & {FLIT_W{tx_en[i]}});
            bus_valid = bus_valid | tx_en[i];
            if (tx_en[i]) begin
                rx_en = rx_en | (LAYERS'(1) << dst[i]);
            end
        end
    end
endmodule

// File: rtl/dtdma_pillar_arbiter.sv
module dtdma_pillar_arbiter #(
    parameter int unsigned LAYERS = 4,
    parameter int unsigned FLIT_W = 128,
    localparam int unsigned IDX_W = $clog2(LAYERS),
    localparam int unsigned CNT_W = $clog2(LAYERS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LAYERS-1:0]             req_i,
    input  logic [LAYERS-1:0][IDX_W-1:0]  dst_i,
    input  logic [LAYERS-1:0][FLIT_W-1:0] flit_i,
    output logic [LAYERS-1:0]             tx_en_o,
    output logic [LAYERS-1:0]             rx_en_o,
    output logic                          bus_valid_o,
    output logic [FLIT_W-1:0]             bus_data_o
);
    logic                          at_boundary;
    logic [CNT_W-1:0]              frame_len;
    logic [CNT_W-1:0]              slot;
    logic [LAYERS-1:0][CNT_W-1:0]  rank;
    logic [LAYERS-1:0]             slot_bits;

    dtdma_slot_seq #(.LAYERS(LAYERS)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req_i),
        .at_boundary (at_boundary),
        .frame_len   (frame_len),
        .slot        (slot),
        .rank        (rank)
    );

    for (genvar g = 0; g < LAYERS; g++) begin : g_layer
        dtdma_pattern_sr #(.LAYERS(LAYERS)) sr_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (at_boundary),
            .member    (req_i[g]),
            .rank      (rank[g]),
            .frame_len (frame_len),
            .slot_bit  (slot_bits[g])
        );
    end

    // A withdrawn request silences its slot without reshaping the frame.
    assign tx_en_o = slot_bits & req_i;

    dtdma_bus_mux #(.LAYERS(LAYERS), .FLIT_W(FLIT_W)) mux_i (
        .tx_en     (tx_en_o),
        .dst       (dst_i),
        .flit      (flit_i),
        .rx_en     (rx_en_o),
        .bus_valid (bus_valid_o),
        .bus_data  (bus_data_o)
    );
endmodule

// File: rtl/dtdma_pillar_arbiter_chk.sv
module dtdma_pillar_arbiter_chk #(
    parameter int unsigned LAYERS = 4,
    parameter int unsigned FLIT_W = 128,
    localparam int unsigned CNT_W = $clog2(LAYERS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LAYERS-1:0] req,
    input logic [LAYERS-1:0] tx_en,
    input logic [LAYERS-1:0] rx_en,
    input logic [FLIT_W-1:0] bus_data,
    input logic              at_boundary,
    input logic [CNT_W-1:0]  frame_len,
    input logic [CNT_W-1:0]  slot
);
    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_en)); // R2

    AST_RX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en != '0) |-> $onehot(rx_en)); // R7

    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en == '0) |-> (bus_data == '0 && rx_en == '0)); // R8

    AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        at_boundary |=> (frame_len == CNT_W'($countones($past(req))) && slot == '0)); // R4

    AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !at_boundary |=> (slot == $past(slot) + 1'b1)); // R4

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_len != '0) |-> (slot < frame_len)); // R4

    AST_HOLD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !at_boundary |=> $stable(frame_len)); // R6
endmodule

bind dtdma_pillar_arbiter dtdma_pillar_arbiter_chk #(.LAYERS(LAYERS), .FLIT_W(FLIT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req_i),
    .tx_en       (tx_en_o),
    .rx_en       (rx_en_o),
    .bus_data    (bus_data_o),
    .at_boundary (at_boundary),
    .frame_len   (frame_len),
    .slot        (slot)
);

// File: tb/dtdma_pillar_arbiter_tb_top.sv
`timescale 1ns/1ps
module dtdma_pillar_arbiter_tb_top;
    localparam int L = 4;
    localparam int W = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [L-1:0] req = '0;
    logic [L-1:0][1:0] dst = '0;
    logic [L-1:0][W-1:0] flit = '0;
    logic [L-1:0] tx_en, rx_en;
    logic bus_valid;
    logic [W-1:0] bus_data;

    int checks = 0, errors = 0, cyc = 0;
    int rem [L];
    int frame_q[$];
    int slot_m = 0;
    int txlog[$];
    bit done = 0;

    always #2 clk = ~clk;

    dtdma_pillar_arbiter #(.LAYERS(L), .FLIT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .dst_i(dst), .flit_i(flit),
        .tx_en_o(tx_en), .rx_en_o(rx_en), .bus_valid_o(bus_valid), .bus_data_o(bus_data)
    );

    // Behavioural frame model: a queue of layer numbers rebuilt at each boundary.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q.delete();
            slot_m = 0;
        end else if (frame_q.size() == 0 || slot_m == frame_q.size() - 1) begin
            frame_q.delete();
            slot_m = 0;
            for (int i = 0; i < L; i++) if (req[i]) frame_q.push_back(i);
        end else begin
            slot_m++;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_cycle();
        int t;
        logic [L-1:0] etx, erx;
        logic [W-1:0] edat;
        t = -1;
        if (frame_q.size() > 0 && req[frame_q[slot_m]]) t = frame_q[slot_m];
        etx = '0; erx = '0; edat = '0;
        if (t >= 0) begin
            etx[t] = 1'b1;
            erx[dst[t]] = 1'b1;
            edat = flit[t];
        end
        chk(tx_en == etx, "R5", "tx_en slot owner", W'(tx_en), W'(etx));
        chk($countones(tx_en) <= 1, "R2", "driver overlap", W'(tx_en), W'(etx));
        chk((tx_en & ~req) == '0, "R3", "tx without request", W'(tx_en), W'(req));
        chk(rx_en == erx, "R7", "rx_en", W'(rx_en), W'(erx));
        chk(bus_data == edat && bus_valid == (t >= 0), "R8", "bus data", bus_data, edat);
    endtask

    task automatic step();
        int who;
        @(negedge clk);
        cyc++;
        compare_cycle();
        who = -1;
        for (int i = 0; i < L; i++) if (tx_en[i]) who = i;
        txlog.push_back(who);
        for (int i = 0; i < L; i++) begin
            if (tx_en[i] && rem[i] > 0) begin
                rem[i]--;
                if (rem[i] == 0) req[i] = 1'b0;
            end
            flit[i] = {8'(i), 120'(cyc * 13 + i)};
        end
    endtask

    task automatic run_idle();
        int n = 0;
        while (req != '0 && n < 200) begin step(); n++; end
        step(); step();
    endtask

    task automatic logchk(input int idx, input int exp, input string tag);
        chk(txlog.size() > idx && txlog[idx] == exp, tag, $sformatf("slot owner at %0d", idx),
            W'(txlog.size() > idx ? txlog[idx] : 99), W'(exp));
    endtask

    initial begin
        for (int i = 0; i < L; i++) rem[i] = 0;
        repeat (3) @(negedge clk);
        chk(tx_en == '0 && rx_en == '0 && !bus_valid && bus_data == '0, "R1", "in reset",
            W'({tx_en, rx_en}), '0);
        rst_n = 1'b1;
        step();
        chk(tx_en == '0 && rx_en == '0 && !bus_valid && bus_data == '0, "R1", "after reset",
            W'({tx_en, rx_en}), '0);

        // Three requesters, three flits each: ascending order, period 3.
        txlog.delete();
        rem[0] = 3; rem[1] = 3; rem[3] = 3;
        dst[0] = 2'd2; dst[1] = 2'd3; dst[3] = 2'd0;
        req = 4'b1011;
        run_idle();
        logchk(0, 0, "R11");
        for (int f = 0; f < 3; f++) begin
            logchk(3*f, 0, "R5"); logchk(3*f+1, 1, "R5"); logchk(3*f+2, 3, "R4");
        end
        logchk(9, -1, "R9");

        // Late joiner waits for the next frame.
        txlog.delete();
        rem[0] = 4; rem[1] = 4; dst[0] = 2'd1; dst[1] = 2'd0;
        req = 4'b0011;
        step();
        req[2] = 1'b1; rem[2] = 2; dst[2] = 2'd3;
        run_idle();
        logchk(0, 0, "R5"); logchk(1, 1, "R6");
        logchk(2, 0, "R6"); logchk(3, 1, "R6"); logchk(4, 2, "R6");

        // A request dropped mid-frame leaves its slot empty.
        txlog.delete();
        rem[0] = 5; rem[1] = 5; rem[2] = 5;
        dst[0] = 2'd3; dst[1] = 2'd2; dst[2] = 2'd1;
        req = 4'b0111;
        step();
        req[1] = 1'b0; rem[1] = 0;
        step(); step(); step(); step();
        logchk(0, 0, "R10"); logchk(1, -1, "R10"); logchk(2, 2, "R10");
        logchk(3, 0, "R4"); logchk(4, 2, "R4");
        req = '0; rem[0] = 0; rem[2] = 0;
        for (int k = 0; k < 3; k++) begin
            step();
            chk(tx_en == '0 && !bus_valid && rx_en == '0, "R9", "idle bus", W'(tx_en), '0);
        end

        // Lone requester holds every slot; layer 3 sends to layer 3.
        txlog.delete();
        rem[3] = 4; dst[3] = 2'd3; req = 4'b1000;
        run_idle();
        for (int k = 0; k < 4; k++) logchk(k, 3, "R4");
        logchk(4, -1, "R9");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule